// File: doc/BRIEF.md
# SRAM Wipe Control and Sticky Fault-Lock Registers

This block is a small memory-mapped configuration slice. It owns a control register that starts a hardware wipe of an SRAM bank. It also owns a configuration register that holds four set-once lock bits and a latched SRAM parity-error flag. Software can start the wipe only after it has written a two-byte unlock sequence to a key register. One unlock allows exactly one control write.

While a wipe runs, a built-in walker drives the SRAM write port. It writes zero to every word, one word per clock, from the lowest address to the highest. The wipe request bit and a busy bit stay set until the walk ends. The top lock bit connects an external flash ECC error line to a registered break output. While that bit is clear, the break output is held low.

The register port is a simple one-cycle bus. A write is taken on the clock edge where `bus_we` is high. Read data is registered, so `bus_rdata` shows the word selected by `bus_addr` on the previous edge. Byte offsets are: control at 0x18, configuration at 0x1C, key at 0x20. Any other offset reads as zero.

Top module: `sram_wipe_ctl`

## Requirements
- R1: After a synchronous reset, the control and configuration registers read 0x0, `brk_o` is 0 and `mem_we_o` is 0.
- R2: Writing 1 to control bit 0 while the block is locked starts no wipe: no SRAM write occurs and control reads back 0.
- R3: The block unlocks only when key register bits 7:0 are written with 0xCA and then, as the next key write, 0x53. Any other key value sends the block back to the locked state, so the sequence 0xCA, 0x11, 0x53 does not unlock it.
- R4: An unlock allows exactly one control write, whatever value that write carries. Any later write of 1 to control bit 0 needs a fresh key sequence.
- R5: A wipe asserts `mem_we_o` for exactly DEPTH consecutive cycles. During those cycles `mem_addr_o` steps through 0 to DEPTH-1 in order and `mem_wdata_o` is zero.
- R6: During a wipe, control reads 0x3 (bit 1 = busy, bit 0 = wipe request). Both bits clear on the edge that performs the last SRAM write. A start request made while busy is ignored.
- R7: Control bits 7:2 and configuration bits 31:9 and 7:4 read 0 whatever is written to them.
- R8: Configuration bit 8 is set when `par_err_i` is high at a clock edge. Writing 1 to bit 8 clears it. Writing 0 to bit 8 leaves it unchanged.
- R9: If `par_err_i` is high on the same edge as a write of 1 to configuration bit 8, the flag stays 1.
- R10: Configuration bits 3:0 are set by writing 1. Writing 0 does not clear them; only reset does.
- R11: `brk_o` equals `ecc_err_i` AND configuration bit 3, registered with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| par_err_i | input | 1 | SRAM parity-error report |
| ecc_err_i | input | 1 | Flash ECC error line |
| brk_o | output | 1 | Gated break output |
| mem_we_o | output | 1 | SRAM write enable during a wipe |
| mem_addr_o | output | 6 | SRAM word address |
| mem_wdata_o | output | 32 | SRAM write data (always zero) |

## Verification
The bench tries broken key sequences, a start request with no key, a second start while a wipe is running, and a start after the single granted write has been used up. A design that relocked too late, or that let the walker restart, would show SRAM writes that the scoreboard queue does not expect. The scoreboard also catches a walk that skips, repeats or stops early at either end of the address range. The bench checks that writing 0 leaves the sticky lock bits set, that the break output stays low until the lock is set, and that a parity report arriving in the same cycle as a clear write still leaves the flag set. A design where the clear wins would read the flag as 0.

// File: rtl/sram_wipe_pkg.sv
package sram_wipe_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_CFG  = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_KEY  = 8'h20;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam int unsigned NUM_LOCKS = 4;
  localparam int unsigned PAR_BIT   = 8;
  localparam int unsigned BRK_LOCK  = 3;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/wipe_key_gate.sv
module wipe_key_gate
  import sram_wipe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_we_i,
  input  logic [7:0] key_val_i,
  input  logic       consume_i,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we_i) begin
      if (key_val_i == KEY_FIRST)
        state_d = KS_HALF;
      else if (key_val_i == KEY_SECOND && state_q == KS_HALF)
        state_d = KS_OPEN;
      else
        state_d = KS_LOCKED;
    end else if (consume_i) begin
      state_d = KS_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_LOCKED;
    else     state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);

  AST_OPEN_NEEDS_SECOND_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> ($past(key_we_i) && $past(key_val_i) == KEY_SECOND)); // R3
  AST_CONSUME_RELOCKS: assert property (@(posedge clk) disable iff (rst)
    (consume_i && !key_we_i) |=> !open_o); // R4
endmodule

// File: rtl/wipe_engine.sv
module wipe_engine #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o
);
  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic          last_w;

  assign last_w = (addr_q == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else if (busy_q) begin
      if (last_w) begin
        busy_q <= 1'b0;
        addr_q <= '0;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      addr_q <= '0;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = busy_q && last_w;
  assign mem_we_o   = busy_q;
  assign mem_addr_o = addr_q;

  AST_ADDR_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && !done_o) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) + 1'b1)); // R5
  AST_WALK_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_o) |-> (mem_addr_o == '0)); // R5
  AST_BUSY_ENDS_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(mem_addr_o) == AW'(DEPTH - 1))); // R6
endmodule

// File: rtl/wipe_cfg_regs.sv
module wipe_cfg_regs
  import sram_wipe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [BUS_DW-1:0]    wdata_i,
  input  logic                 par_err_i,
  output logic [NUM_LOCKS-1:0] lock_o,
  output logic                 par_flag_o
);
  logic [NUM_LOCKS-1:0] lock_q;
  logic                 par_q;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst)                     lock_q[g] <= 1'b0;
      else if (we_i && wdata_i[g]) lock_q[g] <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
      lock_q[g] |=> lock_q[g]); // R10
  end

  always_ff @(posedge clk) begin
    if (rst)                           par_q <= 1'b0;
    else if (par_err_i)                par_q <= 1'b1;
    else if (we_i && wdata_i[PAR_BIT]) par_q <= 1'b0;
  end

  assign lock_o     = lock_q;
  assign par_flag_o = par_q;

  AST_PARITY_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    par_err_i |=> par_flag_o); // R9
  AST_PARITY_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (par_flag_o && !(we_i && wdata_i[PAR_BIT])) |=> par_flag_o); // R8
endmodule

// File: rtl/sram_wipe_ctl.sv
module sram_wipe_ctl
  import sram_wipe_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned MEM_DW = 32,
  localparam int unsigned MEM_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              par_err_i,
  input  logic              ecc_err_i,
  output logic              brk_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [MEM_DW-1:0] mem_wdata_o
);
  logic wr_ctrl, wr_cfg, wr_key;
  logic open_w, start_w, busy_w, done_w;
  logic req_q;
  logic [NUM_LOCKS-1:0] lock_w;
  logic par_flag_w;
  logic [BUS_DW-1:0] rd_d;
  logic brk_q;

  assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
  assign wr_cfg  = bus_we && (bus_addr == OFS_CFG);
  assign wr_key  = bus_we && (bus_addr == OFS_KEY);

  wipe_key_gate u_key (
    .clk       (clk),
    .rst       (rst),
    .key_we_i  (wr_key),
    .key_val_i (bus_wdata[7:0]),
    .consume_i (wr_ctrl),
    .open_o    (open_w)
  );

  assign start_w = wr_ctrl && bus_wdata[0] && open_w && !busy_w;

  wipe_engine #(.DEPTH(DEPTH)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_w),
    .busy_o     (busy_w),
    .done_o     (done_w),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
  );

  assign mem_wdata_o = '0;

  always_ff @(posedge clk) begin
    if (rst)          req_q <= 1'b0;
    else if (start_w) req_q <= 1'b1;
    else if (done_w)  req_q <= 1'b0;
  end

  wipe_cfg_regs u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we_i       (wr_cfg),
    .wdata_i    (bus_wdata),
    .par_err_i  (par_err_i),
    .lock_o     (lock_w),
    .par_flag_o (par_flag_w)
  );

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      OFS_CTRL: rd_d[1:0] = {busy_w, req_q};
      OFS_CFG: begin
        rd_d[NUM_LOCKS-1:0] = lock_w;
        rd_d[PAR_BIT]       = par_flag_w;
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      brk_q     <= 1'b0;
    end else begin
      bus_rdata <= rd_d;
      brk_q     <= ecc_err_i && lock_w[BRK_LOCK];
    end
  end

  assign brk_o = brk_q;

  AST_BRK_NEEDS_ECC: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> $past(ecc_err_i)); // R11
  AST_BRK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> lock_w[BRK_LOCK]); // R11
  AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_w) |-> $past(open_w)); // R2
  AST_REQ_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_q == busy_w); // R6
endmodule

// File: tb/sram_wipe_ctl_tb.sv
module sram_wipe_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int MAW = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        par_err_i, ecc_err_i, brk_o;
  logic        mem_we_o;
  logic [MAW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o;

  int checks = 0;
  int fails = 0;
  int wr_seen = 0;
  bit finished = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_wipe_ctl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .par_err_i(par_err_i),
    .ecc_err_i(ecc_err_i), .brk_o(brk_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every SRAM write must match the queue head (R5)
  always @(negedge clk) begin
    if (!rst && mem_we_o) begin
      wr_seen++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2/R5 actual=write@0x%0h expected=no write", mem_addr_o);
      end else begin
        chk("R5 addr", 32'(mem_addr_o), 32'(exp_q.pop_front()));
        chk("R5 data", mem_wdata_o, 32'h0);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(8'h20, 32'hCA);
    wr(8'h20, 32'h53);
  endtask

  task automatic push_walk();
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(i);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bus_we = 0; bus_addr = 0; bus_wdata = 0; par_err_i = 0; ecc_err_i = 0;
    do_reset();

    // R1 reset state
    rd(8'h18, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h1C, v); chk("R1 cfg", v, 32'h0);
    chk("R1 brk", 32'(brk_o), 32'h0);
    chk("R1 mem_we", 32'(mem_we_o), 32'h0);

    // R2 start without key
    wr(8'h18, 32'h1);
    rd(8'h18, v); chk("R2 ctrl locked", v, 32'h0);

    // R3 broken sequence
    wr(8'h20, 32'hCA); wr(8'h20, 32'h11); wr(8'h20, 32'h53);
    wr(8'h18, 32'h1);
    rd(8'h18, v); chk("R3 bad key", v, 32'h0);

    // R3/R5/R6 good sequence
    unlock();
    push_walk();
    wr(8'h18, 32'h1);
    rd(8'h18, v); chk("R6 busy", v, 32'h3);
    // R6 restart while busy must be ignored
    unlock();
    wr(8'h18, 32'h1);
    repeat (DEPTH + 10) @(negedge clk);
    rd(8'h18, v); chk("R6 done", v, 32'h0);
    chk("R5 count", 32'(wr_seen), 32'(DEPTH));
    chk("R5 queue empty", 32'(exp_q.size()), 32'h0);

    // R4 unlock already consumed
    wr(8'h18, 32'h1);
    repeat (4) @(negedge clk);
    chk("R4 no second", 32'(wr_seen), 32'(DEPTH));
    // R4 consumed by a write of 0
    unlock();
    wr(8'h18, 32'h0);
    wr(8'h18, 32'h1);
    repeat (4) @(negedge clk);
    chk("R4 zero write consumes", 32'(wr_seen), 32'(DEPTH));

    // R7 reserved bits
    wr(8'h1C, 32'hFFFF_FEF0);
    rd(8'h1C, v); chk("R7 cfg reserved", v, 32'h0);
    wr(8'h18, 32'hFC);
    rd(8'h18, v); chk("R7 ctrl reserved", v, 32'h0);

    // R11 break held low while lock clear
    @(negedge clk); ecc_err_i = 1;
    @(negedge clk); chk("R11 unlocked", 32'(brk_o), 32'h0);
    ecc_err_i = 0;

    // R10 locks
    wr(8'h1C, 32'h5);
    rd(8'h1C, v); chk("R10 set", v, 32'h5);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); chk("R10 sticky", v, 32'h5);
    wr(8'h1C, 32'hA);
    rd(8'h1C, v); chk("R10 all", v, 32'hF);

    // R11 break routed
    @(negedge clk); ecc_err_i = 1;
    chk("R11 latency", 32'(brk_o), 32'h0);
    @(negedge clk); chk("R11 routed", 32'(brk_o), 32'h1);
    ecc_err_i = 0;
    @(negedge clk); chk("R11 drop", 32'(brk_o), 32'h0);

    // R8 parity flag
    @(negedge clk); par_err_i = 1;
    @(negedge clk); par_err_i = 0;
    rd(8'h1C, v); chk("R8 set", v, 32'h10F);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); chk("R8 write0", v, 32'h10F);
    wr(8'h1C, 32'h100);
    rd(8'h1C, v); chk("R8 clear", v, 32'h00F);

    // R9 set wins over clear
    @(negedge clk);
    par_err_i = 1; bus_we = 1; bus_addr = 8'h1C; bus_wdata = 32'h100;
    @(negedge clk);
    par_err_i = 0; bus_we = 0;
    rd(8'h1C, v); chk("R9 set wins", v, 32'h10F);

    // R10 only reset clears
    do_reset();
    rd(8'h1C, v); chk("R10 reset", v, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule